// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block tracks the position of a rotary or linear encoder. It takes two encoder inputs, A and B, and keeps a 32-bit position register. The source mode picks how A and B become count pulses and a direction. In x4 quadrature mode every edge of either input counts, and the direction comes from the phase order of the two inputs. In pulse-plus-direction mode, rising edges of A count and the level of B gives the direction. The two external-clock modes count only A, upward or downward, on rising edges or on both edges.

Both encoder inputs pass through two-flop synchronisers before edge detection. A change on an input therefore reaches the position three clock edges after it is first sampled. The position wraps between zero and a programmable ceiling. A small register window lets software read the position and write it, change the ceiling, pick the mode and enable counting. Writes to the 16-bit control registers use the low half of the write data. A quadrature transition in which both inputs change at once is not counted and sets a sticky error output.

Top module: `qpos_counter`

## Requirements
- R1: After reset the position reads 0, the ceiling reads its reset parameter (default 0xFFFFFFFF), both control registers read 0 (counting disabled, quadrature mode) and the error output is 0.
- R2: The position register is at offset 0x00 and the ceiling at 0x08, both 32 bits wide. The decoder control register is at 0x28, with the source code in bits 15:14 and the both-edges select in bit 11. The counter control register is at 0x2a, with the enable in bit 3. Every other bit of the two control registers reads as 0, and unmapped offsets read as 0.
- R3: With source code 0 (x4 quadrature), each single-input change of the synchronised {A,B} pair counts once. The order 00→10→11→01→00 (A leading) counts up, and the reverse order counts down.
- R4: In quadrature mode a sample in which A and B both change is not counted, and it sets the error output, which stays at 1 until reset.
- R5: With source code 1 (pulse plus direction), only rising edges of A count: up while B is 1, down while B is 0. Falling edges of A and any change of B do not count.
- R6: With source code 2 (up only), A counts up: on rising edges only when bit 11 is 0, and on both edges when bit 11 is 1. B has no effect.
- R7: With source code 3 (down only), A counts down under the same edge rule as R6, and B has no effect.
- R8: While enable bit 3 is 0, the position holds its value whatever the inputs do.
- R9: A software write to the position with a value no greater than the current ceiling loads that value. A larger value is refused and the position is left unchanged.
- R10: Counting up from the ceiling (or above it) gives 0, and counting down from 0 gives the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_a_i | input | 1 | Encoder input A (asynchronous) |
| enc_b_i | input | 1 | Encoder input B (asynchronous) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| pos_o | output | 32 | Current position |
| enc_err_o | output | 1 | Sticky illegal-transition flag |

## Verification
The assertions check on every cycle that the position holds while counting is disabled, and that a refused write leaves it unchanged. They also check that the wrap at both ends of the range lands on 0 or on the ceiling, that a double-input change never moves the position, that the error flag never clears, and that B alone never makes a count in the external-clock modes. Only the bench's sweeps can show that each mode counts the right edges in the right direction. The bench walks gray sequences forward and backward with illegal jumps mixed in, covers every mode in both edge settings, and checks each result against an arithmetic model. The register layout, the read-back masks and the accept/refuse limit of position writes are shown the same way.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_PDIR = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_e;

  localparam int unsigned OFF_POS  = 32'h00;
  localparam int unsigned OFF_CEIL = 32'h08;
  localparam int unsigned OFF_DEC  = 32'h28;
  localparam int unsigned OFF_CTL  = 32'h2A;

  localparam int unsigned DEC_SRC_LO = 14;
  localparam int unsigned DEC_BOTH   = 11;
  localparam int unsigned CTL_EN     = 3;
  localparam int unsigned CTRL_W     = 16;
endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  src_e src_i,
  input  logic both_edge_i,
  output logic step_o,
  output logic up_o,
  output logic illegal_o
);
  logic a_q, b_q;
  logic a_chg, b_chg, a_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_chg  = a_i ^ a_q;
  assign b_chg  = b_i ^ b_q;
  assign a_rise = a_i & ~a_q;

  always_comb begin
    step_o    = 1'b0;
    up_o      = 1'b1;
    illegal_o = 1'b0;
    unique case (src_i)
      SRC_QUAD: begin
        step_o    = a_chg ^ b_chg;
        up_o      = b_q ^ a_i;           // A leading B counts up
        illegal_o = a_chg & b_chg;
      end
      SRC_PDIR: begin
        step_o = a_rise;
        up_o   = b_i;
      end
      SRC_UP: begin
        step_o = both_edge_i ? a_chg : a_rise;
        up_o   = 1'b1;
      end
      SRC_DOWN: begin
        step_o = both_edge_i ? a_chg : a_rise;
        up_o   = 1'b0;
      end
      default: ;
    endcase
  end

  // R6, R7: without an A transition the external-clock modes never step
  p_b_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i == SRC_UP || src_i == SRC_DOWN) && a_i == a_q) |-> !step_o);
endmodule

// File: rtl/qpos_count.sv
module qpos_count #(
  parameter int unsigned POS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [POS_W-1:0] ceil_i,
  input  logic             wr_i,
  input  logic [POS_W-1:0] wdata_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q, pos_inc, pos_dec;
  logic             wr_ok;

  assign wr_ok   = wr_i && (wdata_i <= ceil_i);
  assign pos_inc = (pos_q >= ceil_i) ? '0 : pos_q + POS_W'(1);
  assign pos_dec = (pos_q == '0) ? ceil_i : pos_q - POS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pos_q <= '0;
    else if (wr_ok)           pos_q <= wdata_i;
    else if (en_i && step_i)  pos_q <= up_i ? pos_inc : pos_dec;
  end

  assign pos_o = pos_q;

  p_hold_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(pos_o));

  p_refuse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i > ceil_i && !(en_i && step_i)) |=> $stable(pos_o));

  p_wrap_up_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && en_i && step_i && up_i && pos_o >= ceil_i) |=> pos_o == '0);

  p_wrap_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && en_i && step_i && !up_i && pos_o == '0) |=> pos_o == $past(ceil_i));
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int unsigned          POS_W    = 32,
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [POS_W-1:0]     CEIL_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [POS_W-1:0]  reg_wdata_i,
  output logic [POS_W-1:0]  reg_rdata_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              enc_err_o
);
  localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(OFF_POS);
  localparam logic [ADDR_W-1:0] A_CEIL = ADDR_W'(OFF_CEIL);
  localparam logic [ADDR_W-1:0] A_DEC  = ADDR_W'(OFF_DEC);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);

  logic [1:0]       enc_s;
  logic [POS_W-1:0] ceil_q;
  src_e             src_q;
  logic             both_q, en_q, err_q;
  logic             step, up, illegal;
  logic             wr_pos;
  logic [CTRL_W-1:0] dec_rd, ctl_rd;

  qpos_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({enc_a_i, enc_b_i}),
    .q_o   (enc_s)
  );

  qpos_decode u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_i        (enc_s[1]),
    .b_i        (enc_s[0]),
    .src_i      (src_q),
    .both_edge_i(both_q),
    .step_o     (step),
    .up_o       (up),
    .illegal_o  (illegal)
  );

  assign wr_pos = reg_we_i && (reg_addr_i == A_POS);

  qpos_count #(.POS_W(POS_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .step_i (step),
    .up_i   (up),
    .ceil_i (ceil_q),
    .wr_i   (wr_pos),
    .wdata_i(reg_wdata_i),
    .pos_o  (pos_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ceil_q <= CEIL_RST;
      src_q  <= SRC_QUAD;
      both_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CEIL) ceil_q <= reg_wdata_i;
      if (reg_addr_i == A_DEC) begin
        src_q  <= src_e'(reg_wdata_i[DEC_SRC_LO +: 2]);
        both_q <= reg_wdata_i[DEC_BOTH];
      end
      if (reg_addr_i == A_CTL) en_q <= reg_wdata_i[CTL_EN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (illegal) err_q <= 1'b1;
  end

  always_comb begin
    dec_rd = '0;
    dec_rd[DEC_SRC_LO +: 2] = src_q;
    dec_rd[DEC_BOTH]        = both_q;
    ctl_rd = '0;
    ctl_rd[CTL_EN] = en_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_POS:   reg_rdata_o = pos_o;
      A_CEIL:  reg_rdata_o = ceil_q;
      A_DEC:   reg_rdata_o = POS_W'(dec_rd);
      A_CTL:   reg_rdata_o = POS_W'(ctl_rd);
      default: reg_rdata_o = '0;
    endcase
  end

  assign enc_err_o = err_q;

  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_err_o |=> enc_err_o);

  p_illegal_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal && !wr_pos) |=> $stable(pos_o));
endmodule

// File: tb/qpos_counter_bench.sv
module qpos_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ea = 1'b0, eb = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pos;
  logic        err;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] exp_pos = '0, ceil_m = 32'hFFFF_FFFF;
  logic [1:0]  mode = 2'd0;
  logic        both = 1'b0, en = 1'b0;

  always #4 clk = ~clk;

  qpos_counter u_qpos_counter (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(ea), .enc_b_i(eb),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pos_o(pos), .enc_err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_dec(input logic [1:0] m, input logic b);
    mode = m; both = b;
    wr(8'h28, {16'h0, m, 2'b00, b, 11'h0});
  endtask

  task automatic set_en(input logic e);
    en = e;
    wr(8'h2A, {28'h0, e, 3'b000});
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] p, input logic u);
    if (u) return (p >= ceil_m) ? 32'd0 : p + 32'd1;
    return (p == 32'd0) ? ceil_m : p - 32'd1;
  endfunction

  // drive A/B, predict from the requirements, check after the sync latency
  task automatic apply(input logic a, input logic b, input string tag);
    logic st, u;
    st = 1'b0; u = 1'b1;
    case (mode)
      2'd0: begin st = (a != ea) ^ (b != eb); u = eb ^ a; end
      2'd1: begin st = a & ~ea; u = b; end
      2'd2: begin st = both ? (a != ea) : (a & ~ea); u = 1'b1; end
      default: begin st = both ? (a != ea) : (a & ~ea); u = 1'b0; end
    endcase
    if (st && en) exp_pos = nxt(exp_pos, u);
    @(negedge clk);
    ea = a; eb = b;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tag, pos, exp_pos);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  cur;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 pos", d, 32'h0);
    rd(8'h08, d); chk("R1 ceil", d, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R1 dec", d, 32'h0);
    rd(8'h2A, d); chk("R1 ctl", d, 32'h0);
    chk("R1 err", {31'h0, err}, 32'h0);

    // R2 layout and masks
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk("R2 dec mask", d, 32'h0000_C800);
    wr(8'h2A, 32'hFFFF_FFFF); rd(8'h2A, d); chk("R2 ctl mask", d, 32'h0000_0008);
    wr(8'h08, 32'd9); ceil_m = 32'd9; rd(8'h08, d); chk("R2 ceil", d, 32'd9);
    rd(8'h10, d); chk("R2 unmapped", d, 32'h0);
    set_en(1'b0);

    // R8 disabled: quadrature activity ignored
    set_dec(2'd0, 1'b0);
    apply(1, 0, "R8"); apply(1, 1, "R8"); apply(0, 1, "R8"); apply(0, 0, "R8");
    rd(8'h00, d); chk("R8 pos reg", d, 32'h0);
    chk("R4 err clear before illegal", {31'h0, err}, 32'h0);

    // R3/R4/R10 quadrature walk, forward then back, with double changes mixed in
    set_en(1'b1);
    cur = 2'b00;
    for (int k = 0; k < 48; k++) begin
      if (k % 7 == 6) cur = cur ^ 2'b11;
      else if (k < 24) case (cur) 2'b00: cur = 2'b10; 2'b10: cur = 2'b11; 2'b11: cur = 2'b01; default: cur = 2'b00; endcase
      else             case (cur) 2'b00: cur = 2'b01; 2'b01: cur = 2'b11; 2'b11: cur = 2'b10; default: cur = 2'b00; endcase
      apply(cur[1], cur[0], "R3 R4 R10 quad");
    end
    chk("R4 err sticky", {31'h0, err}, 32'h1);

    // R5 pulse plus direction
    set_dec(2'd1, 1'b0);
    for (int k = 0; k < 16; k++) apply(k[0], k[2], "R5 pdir");
    for (int k = 0; k < 8; k++) apply(ea, ~eb, "R5 B only");

    // R6/R7 external clock modes, both edge settings
    for (int m = 2; m < 4; m++) begin
      for (int bo = 0; bo < 2; bo++) begin
        set_dec(2'(m), 1'(bo));
        for (int k = 0; k < 16; k++) apply(k[0], k[1] ^ k[3], m == 2 ? "R6 up" : "R7 down");
      end
    end

    // R9 software writes
    wr(8'h00, 32'd9);  exp_pos = 32'd9; rd(8'h00, d); chk("R9 accept at ceil", d, exp_pos);
    wr(8'h00, 32'd10); rd(8'h00, d); chk("R9 refuse above ceil", d, exp_pos);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R9 refuse max", d, exp_pos);
    wr(8'h00, 32'd3);  exp_pos = 32'd3; rd(8'h00, d); chk("R9 accept", d, exp_pos);

    // R10 wrap down at 0 in down mode
    set_dec(2'd3, 1'b1);
    wr(8'h00, 32'd0); exp_pos = 32'd0;
    apply(~ea, eb, "R10 wrap down");
    apply(~ea, eb, "R10 below ceil");

    // R8 again in pulse mode
    set_en(1'b0);
    set_dec(2'd1, 1'b0);
    for (int k = 0; k < 6; k++) apply(k[0], 1'b1, "R8 hold");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule